// File: doc/BRIEF.md
# Serial Port Status Register with Two-Step Acknowledge

This block holds the status flags of a serial port and presents them as one 16-bit word. Transmitter and receiver logic raise single-cycle set pulses. A flag stays set until software acknowledges it. To acknowledge, software first reads the status word while the flag shows 1. It then accesses the data register: a read for receive-side flags, a write for the two transmit-side flags.

Each status read captures which flags were visible at that moment. The next data access clears only those flags, and only the ones of the class that the access serves. A flag that rises between the two steps is not in the captured set, so it survives the access. A long-word read spans both registers in one access. It clears the receive flags that are set at that moment and also records the transmit flags for a later data write. The receiver-busy bit is live status and is never acknowledged.

Top module: `serstat_ack`

## Requirements
- R1: The status word places the flags at fixed bits: 8 tx-empty, 7 tx-done, 6 rx-full, 5 rx-busy, 4 rx-idle, 3 overrun, 2 noise, 1 framing, 0 parity. Bits 15..9 read 0. After reset the word is 0x0180.
- R2: A set pulse makes its flag 1 from the next cycle, and the flag stays 1 until it is acknowledged. Pulses that arrive in the same cycle (for example rx-full together with noise) all appear in the same cycle.
- R3: A status read (bus_rd with sel_stat) followed by a plain data read (bus_rd with sel_data) clears the receive flags (bits 6,4,3,2,1,0) that were 1 at the status read.
- R4: The transmit flags (bits 8,7) clear only through a status read followed by a data write (bus_wr with sel_data). A data read leaves them set and keeps their acknowledge pending. A data write leaves the receive flags set.
- R5: A flag that sets after the status read and before the data access is not cleared by that access.
- R6: A status read of any size counts as an observation of all flags, including a byte read (acc_size 00) of either half. Word size is 01.
- R7: A long-word status read (acc_size 10 with sel_stat) clears, in that same access, the receive flags that are 1 at that moment. It leaves the transmit flags set, but records them so that a following data write clears them.
- R8: When a set pulse arrives in the same cycle as an access that would clear its flag, the flag stays 1 and no clear pulse is given for it.
- R9: rx-busy (bit 5) goes to 1 the cycle after rx_start_seen and to 0 the cycle after rx_line_idle. rx_start_seen wins when both arrive together. The acknowledge sequence never changes it.
- R10: flag_clr pulses for one cycle, in the cycle of the clearing access, only for flags that are 1. Its bit 5 is never set. The flag reads 0 in the next cycle.
- R11: A data access clears nothing unless a status read came before it. Once an observation has been used by a data access, it is spent, and a later access of the same kind clears nothing until the next status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_empty_set | input | 1 | Set pulse: transmit holding register emptied |
| tx_done_set | input | 1 | Set pulse: transmitter went idle |
| rx_full_set | input | 1 | Set pulse: received word available |
| rx_idle_set | input | 1 | Set pulse: idle line detected |
| rx_overrun_set | input | 1 | Set pulse: receive overrun |
| rx_noise_set | input | 1 | Set pulse: noise seen on received word |
| rx_frame_set | input | 1 | Set pulse: framing error |
| rx_parity_set | input | 1 | Set pulse: parity error |
| rx_start_seen | input | 1 | Receiver detected a possible start bit |
| rx_line_idle | input | 1 | Receiver detected its idle condition |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| sel_stat | input | 1 | Access selects the status register |
| sel_data | input | 1 | Access selects the data register |
| acc_size | input | 2 | Access size: 00 byte, 01 word, 10 long word |
| stat_word | output | 16 | Current status word |
| flag_clr | output | 9 | Per-flag clear pulses, same bit positions as the status word |

## Verification
Assertions check several properties on every cycle. A clear pulse only ever hits a flag that is 1, and that flag reads 0 in the next cycle. A set pulse always shows in the next cycle. Transmit clears happen only on data writes, and receive clears only on reads. The busy bit follows its start and idle inputs. The reset value is checked once, when reset ends. Other behaviour depends on the order of events, which only the bench scenarios can show. This covers flags that survive because they rose between the two steps, and the byte read and long-word read variants. It also covers an observation that is spent after use, transmit flags that stay pending across a data read, and the same-cycle race between set and clear.

// File: rtl/serstat_ack.sv
module serstat_ack #(
  parameter int FLAG_W = 9,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_empty_set,
  input  logic              tx_done_set,
  input  logic              rx_full_set,
  input  logic              rx_idle_set,
  input  logic              rx_overrun_set,
  input  logic              rx_noise_set,
  input  logic              rx_frame_set,
  input  logic              rx_parity_set,
  input  logic              rx_start_seen,
  input  logic              rx_line_idle,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              sel_stat,
  input  logic              sel_data,
  input  logic [1:0]        acc_size,
  output logic [WORD_W-1:0] stat_word,
  output logic [FLAG_W-1:0] flag_clr
);
  localparam logic [FLAG_W-1:0] TX_M  = FLAG_W'(9'h180);
  localparam logic [FLAG_W-1:0] RX_M  = FLAG_W'(9'h05F);
  localparam logic [FLAG_W-1:0] RST_V = FLAG_W'(9'h180);
  localparam int BUSY_B = 5;

  logic [FLAG_W-1:0] flags_q, seen_q, set_vec, rx_clr, tx_clr;
  logic long_rd, stat_rd, data_rd, data_wr;

  assign set_vec = {tx_empty_set, tx_done_set, rx_full_set, 1'b0, rx_idle_set,
                    rx_overrun_set, rx_noise_set, rx_frame_set, rx_parity_set};

  assign stat_rd = bus_rd & sel_stat;
  assign long_rd = stat_rd & (acc_size == 2'b10);
  assign data_rd = bus_rd & sel_data & ~sel_stat;
  assign data_wr = bus_wr & sel_data;

  assign rx_clr = long_rd ? (flags_q & RX_M)
                : data_rd ? (seen_q & flags_q & RX_M) : '0;
  assign tx_clr = data_wr ? (seen_q & flags_q & TX_M) : '0;
  assign flag_clr = (rx_clr | tx_clr) & ~set_vec;

  assign stat_word = {{(WORD_W-FLAG_W){1'b0}}, flags_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= RST_V;
    end else begin
      flags_q <= (flags_q & ~flag_clr) | set_vec;
      if (rx_start_seen)     flags_q[BUSY_B] <= 1'b1;
      else if (rx_line_idle) flags_q[BUSY_B] <= 1'b0;
      else                   flags_q[BUSY_B] <= flags_q[BUSY_B];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
    end else if (long_rd) begin
      seen_q <= flags_q & TX_M;
    end else if (stat_rd) begin
      seen_q <= flags_q & (TX_M | RX_M);
    end else if (data_rd) begin
      seen_q <= seen_q & ~RX_M;
    end else if (data_wr) begin
      seen_q <= seen_q & ~TX_M;
    end
  end

  a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> stat_word == WORD_W'(16'h0180));

  a_r2_set_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((stat_word[FLAG_W-1:0] & $past(set_vec)) == $past(set_vec)));

  a_r10_clr_only_set: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr & ~stat_word[FLAG_W-1:0]) == '0);

  a_r10_clr_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr != '0) |=> ((stat_word[FLAG_W-1:0] & $past(flag_clr)) == '0));

  a_r4_tx_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_clr & TX_M) != '0) |-> (bus_wr && sel_data));

  a_r3_rx_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_clr & RX_M) != '0) |-> bus_rd);

  a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    rx_start_seen |=> stat_word[BUSY_B]);

  a_r9_busy_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_line_idle && !rx_start_seen) |=> !stat_word[BUSY_B]);
endmodule

// File: tb/serstat_ack_bench.sv
module serstat_ack_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [8:0] setv = '0;
  logic idle = 1'b0, rd = 1'b0, wr = 1'b0, ss = 1'b0, sd = 1'b0;
  logic [1:0] sz = 2'b01;
  logic [15:0] stat_word;
  logic [8:0] flag_clr;

  always #4 clk = ~clk;

  serstat_ack u_serstat_ack (
    .clk(clk), .rst_n(rst_n),
    .tx_empty_set(setv[8]), .tx_done_set(setv[7]), .rx_full_set(setv[6]),
    .rx_idle_set(setv[4]), .rx_overrun_set(setv[3]), .rx_noise_set(setv[2]),
    .rx_frame_set(setv[1]), .rx_parity_set(setv[0]),
    .rx_start_seen(setv[5]), .rx_line_idle(idle),
    .bus_rd(rd), .bus_wr(wr), .sel_stat(ss), .sel_data(sd), .acc_size(sz),
    .stat_word(stat_word), .flag_clr(flag_clr));

  typedef struct { logic [8:0] clr; logic [15:0] stat; string tag; } item_t;
  item_t q[$];
  int errors = 0, checks = 0;
  logic [8:0] m = 9'h180, s = '0;
  localparam logic [8:0] TXM = 9'h180, RXM = 9'h05F;

  task automatic cyc(input logic [8:0] st, input logic id, input logic r, input logic w,
                     input logic a_s, input logic a_d, input logic [1:0] z, input string tag);
    logic lrd, srd, drd, dwr;
    logic [8:0] sv, c;
    item_t it;
    @(negedge clk);
    setv = st; idle = id; rd = r; wr = w; ss = a_s; sd = a_d; sz = z;
    sv = st & ~9'h020;
    srd = r & a_s; lrd = srd & (z == 2'b10); drd = r & a_d & ~a_s; dwr = w & a_d;
    c = lrd ? (m & RXM) : drd ? (s & m & RXM) : '0;
    if (dwr) c = c | (s & m & TXM);
    c = c & ~sv;
    if (lrd) s = m & TXM;
    else if (srd) s = m & (TXM | RXM);
    else if (drd) s = s & ~RXM;
    else if (dwr) s = s & ~TXM;
    m = (m & ~c) | sv;
    m[5] = st[5] ? 1'b1 : id ? 1'b0 : m[5];
    it.clr = c; it.stat = {7'b0, m}; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic nop(input string tag);       cyc('0, 0, 0, 0, 0, 0, 2'b01, tag); endtask
  task automatic pulse(input logic [8:0] v, input string tag); cyc(v, 0, 0, 0, 0, 0, 2'b01, tag); endtask
  task automatic srd(input logic [1:0] z, input string tag);   cyc('0, 0, 1, 0, 1, 0, z, tag); endtask
  task automatic drd(input logic [8:0] v, input string tag);   cyc(v, 0, 1, 0, 0, 1, 2'b01, tag); endtask
  task automatic dwr(input string tag);       cyc('0, 0, 0, 1, 0, 1, 2'b01, tag); endtask

  always begin
    item_t it;
    logic [8:0] got_clr;
    @(negedge clk); #2;
    if (q.size() > 0) begin
      got_clr = flag_clr;
      @(posedge clk); #1;
      it = q.pop_front();
      checks += 2;
      if (got_clr !== it.clr) begin
        errors++;
        $display("FAIL %s flag_clr got %h expected %h", it.tag, got_clr, it.clr);
      end
      if (stat_word !== it.stat) begin
        errors++;
        $display("FAIL %s stat_word got %h expected %h", it.tag, stat_word, it.stat);
      end
    end
  end

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (stat_word !== 16'h0180) begin
      errors++;
      $display("FAIL R1 reset word got %h expected 0180", stat_word);
    end
    rst_n = 1'b1;
    nop("R1 idle after reset");
    pulse(9'h044, "R2 rx-full with noise");
    nop("R2 flags sticky");
    drd('0, "R11 data read without status read");
    srd(2'b01, "R3 status read");
    drd('0, "R3 data read clears rx");
    dwr("R4 status read then write clears tx");
    srd(2'b01, "R4 status read empty");
    pulse(9'h180, "R4 set tx");
    srd(2'b01, "R4 status read tx seen");
    pulse(9'h008, "R4 set overrun");
    drd('0, "R4 data read keeps tx");
    srd(2'b01, "R4 observe overrun");
    dwr("R4 write clears tx not rx");
    drd('0, "R3 read clears overrun");
    pulse(9'h001, "R5 set parity");
    srd(2'b01, "R5 status read");
    pulse(9'h002, "R5 set framing between steps");
    drd('0, "R5 framing survives");
    srd(2'b00, "R6 byte status read");
    drd('0, "R6 byte read acknowledges framing");
    pulse(9'h140, "R7 set rx-full and tx-empty");
    srd(2'b10, "R7 long read clears rx only");
    dwr("R7 tx recorded by long read");
    pulse(9'h008, "R8 set overrun");
    srd(2'b01, "R8 status read");
    drd(9'h008, "R8 set beats clear");
    nop("R8 flag held");
    drd('0, "R11 observation spent");
    pulse(9'h020, "R9 start seen");
    srd(2'b01, "R9 status read with busy");
    drd('0, "R9 busy not acknowledged");
    cyc('0, 1, 0, 0, 0, 0, 2'b01, "R9 idle clears busy");
    cyc(9'h020, 1, 0, 0, 0, 0, 2'b01, "R9 start wins over idle");
    pulse(9'h010, "R10 set idle-detected");
    srd(2'b01, "R10 status read");
    drd('0, "R10 single clear pulse");
    nop("R10 no repeat pulse");
    repeat (3) @(posedge clk);
    #2;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule